// File: doc/BRIEF.md
# I2C Register Access Slave

This block lets an external controller on a two-wire I2C bus read and write a bank of internal control and status registers. Every transaction opens with a 7-bit chip address and a direction bit. A write then carries one subaddress byte, which selects the register, followed by its data. A read first writes the subaddress, then issues a repeated START with the read bit set, and collects the data. 16-bit values always travel high byte first. The chip address is one of three values, chosen by a select pin that a board ties to supply, to a mid reference or to ground. The pin's level arrives here already coded as two bits.

Register storage lives outside the block, behind a plain synchronous port. A write strobe carries the subaddress and a 16-bit value. A read request is answered later by a valid pulse with data. While the answer is pending, the slave holds SCL low, so the latency of the storage never shows up as a bus timing error. Subaddresses at or above `BYTE_BASE` hold 8-bit registers, which take a single write byte. A parameterised range holds narrow registers that implement only `NARROW_W` bits. Their unused upper bits are dropped on write and return as zero on read.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave ACKs the chip address 7'b1000111 when sel_code is 2'b10, 7'b1000110 when it is 2'b01, and 7'b1000100 when it is 2'b00. Code 2'b11 matches no address.
- R2: A chip address that does not match gets no ACK. The slave then drives neither SDA nor SCL and makes no register access until the next START.
- R3: A write of chip address (bit 0 = 0), subaddress, high byte and low byte to a 16-bit register gives one reg_wr pulse. That pulse carries reg_addr = subaddress and reg_wdata = {high, low}, and every byte is ACKed.
- R4: A read, made of subaddress write, repeated START and chip address with bit 0 = 1, raises exactly one one-cycle reg_rd for the stored subaddress. It returns the high byte and then the low byte, MSB first. After the master NAKs, SDA is released.
- R5: From the ACK of a read address until reg_rvalid, the slave holds SCL low. It releases SCL in the cycle after reg_rvalid. SDA does not change while SCL is high during data output.
- R6: For subaddresses NARROW_LO..NARROW_HI (default 0x20..0x2F, NARROW_W = 9), bits above NARROW_W-1 are written as 0 and read back as 0.
- R7: For subaddresses >= BYTE_BASE (default 0xC0), a single data byte b commits reg_wdata = {8'h00, b}, and any further write byte is NAKed. A read returns the low 8 bits of the register, then 0x00.
- R8: A STOP or a START in the middle of a transfer aborts it. A 16-bit write that has received only its high byte produces no reg_wr.
- R9: After a 16-bit register has received two data bytes, a further write byte is NAKed and causes no further reg_wr.
- R10: During and after reset, sda_oe, scl_oe, reg_wr and reg_rd are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sel_code | input | 2 | Chip address select: 2'b10 supply, 2'b01 mid, 2'b00 ground |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or a 0 data bit) |
| reg_addr | output | 8 | Current subaddress |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 16 | Write value, with unimplemented bits cleared |
| reg_rd | output | 1 | One-cycle register read request |
| reg_rvalid | input | 1 | Read data valid, at least one cycle after reg_rd |
| reg_rdata | input | 16 | Read data from the register file |

## Verification
The in-line assertions guard rules that hold cycle by cycle:
- reg_rd is a single pulse.
- SCL is released in the cycle after read data arrives.
- SDA stays steady while SCL is high during output.
- STOP releases both lines.
- Narrow and byte registers never receive set upper bits.
- An unaddressed slave stays off the bus.

Whole transactions can only be shown by the bench's scenarios, which run on an open-drain bus model:
- the address choice for each select code;
- the byte order on write and read;
- the loss of a half-received write on STOP or repeated START;
- the NAK of surplus bytes;
- a stretch long enough for the master to observe.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [7:0] NARROW_LO = 8'h20,
  parameter logic [7:0] NARROW_HI = 8'h2F,
  parameter int         NARROW_W  = 9,
  parameter logic [7:0] BYTE_BASE = 8'hC0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  sel_code,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic [7:0]  reg_addr,
  output logic        reg_wr,
  output logic [15:0] reg_wdata,
  output logic        reg_rd,
  input  logic        reg_rvalid,
  input  logic [15:0] reg_rdata
);

  localparam logic [15:0] NMASK  = 16'((32'd1 << NARROW_W) - 1);
  localparam logic [1:0]  K_ADDR = 2'd0;
  localparam logic [1:0]  K_SUB  = 2'd1;
  localparam logic [1:0]  K_DATA = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_LOAD, S_SKIP} state_t;

  logic [1:0]  scl_sy, sda_sy;
  logic        scl_q, sda_q;
  state_t      state;
  logic [1:0]  kind, nbytes;
  logic [3:0]  bitcnt;
  logic [7:0]  rx, hi;
  logic [15:0] tx;
  logic        rd_mode, ld_sent, mack;
  logic [6:0]  chip;
  logic        chip_ok;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire byte_done = scl_fall && bitcnt == 4'd8;

  wire is_byte   = reg_addr >= BYTE_BASE;
  wire is_narrow = reg_addr >= NARROW_LO && reg_addr <= NARROW_HI;
  wire [15:0] wmask  = is_byte ? 16'h00FF : (is_narrow ? NMASK : 16'hFFFF);
  wire [15:0] rd_val = reg_rdata & wmask;

  always_comb begin
    chip_ok = 1'b1;
    case (sel_code)
      2'b10:   chip = 7'b1000111;
      2'b01:   chip = 7'b1000110;
      2'b00:   chip = 7'b1000100;
      default: begin chip = 7'b0; chip_ok = 1'b0; end
    endcase
  end

  assign sda_oe = (state == S_ACK) | (state == S_TX & ~tx[15]);
  assign scl_oe = (state == S_LOAD);
  assign reg_rd = (state == S_LOAD) & ~ld_sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      kind      <= K_ADDR;
      nbytes    <= 2'd0;
      bitcnt    <= 4'd0;
      rx        <= 8'h00;
      hi        <= 8'h00;
      tx        <= 16'h0000;
      rd_mode   <= 1'b0;
      ld_sent   <= 1'b0;
      mack      <= 1'b0;
      reg_addr  <= 8'h00;
      reg_wr    <= 1'b0;
      reg_wdata <= 16'h0000;
    end else begin
      reg_wr <= 1'b0;
      if (start_det) begin
        state  <= S_RX;
        kind   <= K_ADDR;
        bitcnt <= 4'd0;
        nbytes <= 2'd0;
      end else if (stop_det) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise) begin
              rx     <= {rx[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= 4'd0;
              case (kind)
                K_ADDR: begin
                  if (chip_ok && rx[7:1] == chip) begin
                    rd_mode <= rx[0];
                    kind    <= K_SUB;
                    state   <= S_ACK;
                  end else begin
                    state <= S_SKIP;
                  end
                end
                K_SUB: begin
                  reg_addr <= rx;
                  nbytes   <= 2'd0;
                  kind     <= K_DATA;
                  state    <= S_ACK;
                end
                default: begin
                  if (is_byte) begin
                    if (nbytes == 2'd0) begin
                      reg_wr    <= 1'b1;
                      reg_wdata <= {8'h00, rx} & wmask;
                      nbytes    <= 2'd1;
                      state     <= S_ACK;
                    end else begin
                      state <= S_SKIP;
                    end
                  end else if (nbytes == 2'd0) begin
                    hi     <= rx;
                    nbytes <= 2'd1;
                    state  <= S_ACK;
                  end else if (nbytes == 2'd1) begin
                    reg_wr    <= 1'b1;
                    reg_wdata <= {hi, rx} & wmask;
                    nbytes    <= 2'd2;
                    state     <= S_ACK;
                  end else begin
                    state <= S_SKIP;
                  end
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              state   <= rd_mode ? S_LOAD : S_RX;
              ld_sent <= 1'b0;
            end
          end
          S_LOAD: begin
            ld_sent <= 1'b1;
            if (reg_rvalid && ld_sent) begin
              tx     <= is_byte ? {rd_val[7:0], 8'h00} : rd_val;
              bitcnt <= 4'd0;
              state  <= S_TX;
            end
          end
          S_TX: begin
            if (scl_fall) begin
              tx <= tx << 1;
              if (bitcnt == 4'd7) begin
                bitcnt <= 4'd0;
                state  <= S_MACK;
              end else begin
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) state <= mack ? S_TX : S_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> (!sda_oe && !scl_oe && !reg_rd)) else $error("skip drives bus"); // R2
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd) else $error("reg_rd longer than one cycle"); // R4
  AST_STRETCH_END: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && reg_rvalid && !reg_rd) |=> !scl_oe) else $error("SCL held after data"); // R5
  AST_SDA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TX && $past(state == S_TX) && scl_s && scl_q) |-> $stable(sda_oe)) else $error("SDA moved with SCL high"); // R5
  AST_NARROW_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr >= NARROW_LO && reg_addr <= NARROW_HI) |-> ((reg_wdata & ~NMASK) == 16'h0)) else $error("narrow upper bits set"); // R6
  AST_BYTE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr >= BYTE_BASE) |-> (reg_wdata[15:8] == 8'h00)) else $error("byte reg upper set"); // R7
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !scl_oe)) else $error("lines held after STOP"); // R8

endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb_top;
  localparam int H = 20;
  localparam int RDLY = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] sel_code = 2'b10;
  logic scl_oe, sda_oe, reg_wr, reg_rd;
  logic [7:0] reg_addr;
  logic [15:0] reg_wdata;
  logic reg_rvalid = 1'b0;
  logic [15:0] reg_rdata = 16'h0;

  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_reg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .sel_code(sel_code), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata)
  );

  int errors = 0, checks = 0, rd_reqs = 0, stretch_cnt = 0;
  bit done = 0;
  string cur_req = "R10";
  logic [23:0] exp_q[$];
  logic [15:0] rf [256];
  bit rd_pend = 0;
  int rd_timer = 0;
  logic [6:0] dev = 7'b1000111;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // register file model and scoreboard monitor
  always @(negedge clk) begin
    reg_rvalid = 1'b0;
    if (scl_m && !scl_line) stretch_cnt++;
    if (reg_wr) begin
      rf[reg_addr] = reg_wdata;
      if (exp_q.size() == 0) chk(0, {cur_req, " unexpected write"}, {reg_addr, reg_wdata}, 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e, {cur_req, " write"}, {reg_addr, reg_wdata}, e);
      end
    end
    if (reg_rd) begin
      rd_pend = 1; rd_timer = RDLY; rd_reqs++;
    end else if (rd_pend) begin
      if (rd_timer == 0) begin
        reg_rvalid = 1'b1; reg_rdata = rf[reg_addr]; rd_pend = 0;
      end else rd_timer--;
    end
  end

  task automatic hwait(input int n = H); repeat (n) @(negedge clk); endtask
  task automatic scl_up(); scl_m = 1; while (!scl_line) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1; hwait(); scl_up(); hwait(); sda_m = 0; hwait(); scl_m = 0; hwait();
  endtask

  task automatic i2c_stop();
    sda_m = 0; hwait(); scl_up(); hwait(); sda_m = 1; hwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hwait(); scl_up(); hwait(); scl_m = 0;
    end
    sda_m = 1; hwait(); scl_up(); hwait(H/2); ack = !sda_line; hwait(H/2); scl_m = 0;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hwait(); scl_up(); hwait(H/2); b[i] = sda_line; hwait(H/2); scl_m = 0;
    end
    sda_m = !ack; hwait(); scl_up(); hwait(); scl_m = 0; sda_m = 1;
  endtask

  task automatic push(input logic [7:0] a, input logic [15:0] d); exp_q.push_back({a, d}); endtask

  task automatic write_word(input logic [7:0] sa, input logic [15:0] v, output bit [3:0] acks);
    i2c_start();
    send_byte({dev, 1'b0}, acks[3]); send_byte(sa, acks[2]);
    send_byte(v[15:8], acks[1]); send_byte(v[7:0], acks[0]);
    i2c_stop();
  endtask

  task automatic read_word(input logic [7:0] sa, output logic [7:0] h, output logic [7:0] l, output bit [2:0] acks);
    i2c_start();
    send_byte({dev, 1'b0}, acks[2]); send_byte(sa, acks[1]);
    i2c_start();
    send_byte({dev, 1'b1}, acks[0]);
    recv_byte(1, h); recv_byte(0, l);
    i2c_stop();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [3:0] wa; bit [2:0] ra; bit a, b2;
    logic [7:0] h, l;
    int rq0, st0;
    for (int i = 0; i < 256; i++) rf[i] = 16'h0;
    repeat (5) @(negedge clk);
    chk(!sda_oe && !scl_oe && !reg_wr && !reg_rd, "R10 reset outputs", {sda_oe, scl_oe, reg_wr, reg_rd}, 0);
    rst_n = 1; hwait();
    chk(!sda_oe && !scl_oe && !reg_wr && !reg_rd, "R10 after reset", {sda_oe, scl_oe, reg_wr, reg_rd}, 0);

    cur_req = "R3"; sel_code = 2'b10; dev = 7'b1000111;
    push(8'h10, 16'h1234);
    write_word(8'h10, 16'h1234, wa);
    chk(wa == 4'hF, "R1 R3 supply write acks", wa, 4'hF);

    cur_req = "R4"; rq0 = rd_reqs; st0 = stretch_cnt;
    read_word(8'h10, h, l, ra);
    chk(ra == 3'h7, "R4 read acks", ra, 3'h7);
    chk({h, l} == 16'h1234, "R4 read bytes", {h, l}, 16'h1234);
    chk(rd_reqs - rq0 == 1, "R4 one reg_rd", rd_reqs - rq0, 1);
    chk(stretch_cnt - st0 > RDLY / 2, "R5 SCL stretched", stretch_cnt - st0, RDLY);
    chk(!sda_oe && !scl_oe, "R4 lines released", {sda_oe, scl_oe}, 0);

    cur_req = "R2"; rq0 = rd_reqs; dev = 7'b1000110;
    write_word(8'h10, 16'hDEAD, wa);
    chk(wa == 4'h0, "R2 wrong address no ack", wa, 0);
    chk(rd_reqs == rq0 && !sda_oe, "R2 bus quiet", rd_reqs - rq0, 0);

    cur_req = "R1"; sel_code = 2'b01; dev = 7'b1000110;
    push(8'h30, 16'hBEEF);
    write_word(8'h30, 16'hBEEF, wa);
    chk(wa == 4'hF, "R1 mid select", wa, 4'hF);
    sel_code = 2'b00; dev = 7'b1000100;
    push(8'h31, 16'h0F0F);
    write_word(8'h31, 16'h0F0F, wa);
    chk(wa == 4'hF, "R1 ground select", wa, 4'hF);
    dev = 7'b1000111;
    i2c_start(); send_byte({dev, 1'b0}, a); i2c_stop();
    chk(!a, "R1 supply address rejected on ground", a, 0);
    sel_code = 2'b11; dev = 7'b1000100;
    i2c_start(); send_byte({dev, 1'b0}, a); i2c_stop();
    chk(!a, "R1 code 11 matches nothing", a, 0);

    sel_code = 2'b10; dev = 7'b1000111;
    cur_req = "R6";
    push(8'h22, 16'h01CD);
    write_word(8'h22, 16'hABCD, wa);
    chk(wa == 4'hF, "R6 narrow write acks", wa, 4'hF);
    rf[8'h25] = 16'hFFFF;
    read_word(8'h25, h, l, ra);
    chk({h, l} == 16'h01FF, "R6 narrow read zero upper", {h, l}, 16'h01FF);

    cur_req = "R7";
    push(8'hC4, 16'h005A);
    i2c_start(); send_byte({dev, 1'b0}, a); send_byte(8'hC4, a); send_byte(8'h5A, a); send_byte(8'h77, b2); i2c_stop();
    chk(a && !b2, "R7 byte write ack then nak", {a, b2}, 2'b10);
    rf[8'hC4] = 16'h335A;
    read_word(8'hC4, h, l, ra);
    chk({h, l} == 16'h5A00, "R7 byte read", {h, l}, 16'h5A00);

    cur_req = "R8";
    i2c_start(); send_byte({dev, 1'b0}, a); send_byte(8'h11, a); send_byte(8'h77, a); i2c_stop();
    i2c_start(); send_byte({dev, 1'b0}, a); send_byte(8'h12, a); send_byte(8'h88, a);
    push(8'h13, 16'h9999);
    i2c_start(); send_byte({dev, 1'b0}, a); send_byte(8'h13, a); send_byte(8'h99, a); send_byte(8'h99, a); i2c_stop();
    chk(exp_q.size() == 0 && rf[8'h11] == 0 && rf[8'h12] == 0, "R8 partial writes dropped", rf[8'h12], 0);

    cur_req = "R9";
    push(8'h14, 16'hAABB);
    i2c_start(); send_byte({dev, 1'b0}, a); send_byte(8'h14, a);
    send_byte(8'hAA, a); send_byte(8'hBB, a); send_byte(8'hCC, b2); i2c_stop();
    chk(a && !b2, "R9 third byte nak", {a, b2}, 2'b10);
    hwait();
    chk(exp_q.size() == 0 && rf[8'h14] == 16'hAABB, "R3 R9 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule